// File: doc/BRIEF.md
# Unlock-Sequence Command Detector

This block sits beside a byte-wide memory port that is backed by a non-volatile shadow array. It watches the read cycles on that port, and it recognises a fixed unlock code. The code is six reads in a row. The first five reads go to fixed key addresses, and the sixth address names a command. The reads still return ordinary memory data; this block only observes them. When the sixth read names a known command, the block raises a one-cycle pulse on one line of a four-bit command vector. The store/recall sequencer takes that pulse.

A read strobe is the clock cycle in which chip enable (active low) is first seen low while write enable (active low) is high. Chip enable, write enable and the address are assumed to be already synchronous to `clk`.

The detector goes back to its idle step in these cases:
- a write cycle occurs;
- a read goes to an address that does not fit the sequence;
- the supply-good input is low;
- the sequencer reports busy.

Top module: `nvs_unlock_seq`

## Requirements
- R1: After reset, `cmd_pulse` is 0 and the detector waits for the first key address.
- R2: Six read strobes with key addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 raise `cmd_pulse[0]` (store) in the cycle after the sixth strobe.
- R3: When the sixth address is 0x0C63, the pulse appears on `cmd_pulse[1]` (recall).
- R4: When the sixth address is 0x07F0, the pulse appears on `cmd_pulse[2]` (background-store enable). When it is 0x03F8, the pulse appears on `cmd_pulse[3]` (background-store disable).
- R5: Only address bits 13:0 are compared. Bit 14 has no effect on any step.
- R6: A write cycle (`ce_n` low with `we_n` low) at any point returns the detector to idle. The remaining reads of that sequence then raise no pulse.
- R7: A read to an address that does not fit the current step aborts the sequence. If that read is to 0x0E38, it counts as the first step of a new sequence.
- R8: An unrecognised sixth address raises no pulse.
- R9: While `vcc_ok` is low, the detector is held idle and no pulse is raised. A sequence that was in progress must start again.
- R10: While `seq_busy` is high, the detector is held idle and no pulse is raised.
- R11: At most one bit of `cmd_pulse` is high at a time, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable of the memory port, active low |
| we_n | input | 1 | Write enable of the memory port, active low |
| addr | input | 15 | Address of the memory port |
| vcc_ok | input | 1 | High while the supply is above the switch threshold |
| seq_busy | input | 1 | High while the store/recall sequencer is busy |
| cmd_pulse | output | 4 | One-hot command pulse: [0] store, [1] recall, [2] enable, [3] disable |

## Verification
The assertions check these properties on every cycle:
- the pulse vector is one-hot or zero;
- every pulse lasts one cycle;
- every pulse follows a read strobe and leaves the detector idle;
- a write, a low supply or a busy sequencer always forces the idle step and blocks the pulse.

Only the bench scenarios can show that a pulse lands on the right line. They drive the exact ordered key stream, address-bit-14 aliasing, an abort followed by a restart on the first key, and sequences broken by a write, by a low supply or by a busy sequencer.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int KEY_W   = 14;
  localparam int SEQ_LEN = 6;
  localparam int NUM_CMD = 4;

  typedef struct packed {
    logic               hit;
    logic [NUM_CMD-1:0] onehot;
  } cmd_t;

  // Key address expected at each of the first five steps.
  function automatic logic [KEY_W-1:0] key_at(input int idx);
    case (idx)
      0:       key_at = 14'h0E38;
      1:       key_at = 14'h31C7;
      2:       key_at = 14'h03E0;
      3:       key_at = 14'h3C1F;
      default: key_at = 14'h303F;
    endcase
  endfunction

  // Sixth-address decode: store, recall, enable, disable.
  function automatic cmd_t cmd_lookup(input logic [KEY_W-1:0] a);
    cmd_t c;
    c.hit    = 1'b1;
    c.onehot = '0;
    case (a)
      14'h0FC0: c.onehot[0] = 1'b1;
      14'h0C63: c.onehot[1] = 1'b1;
      14'h07F0: c.onehot[2] = 1'b1;
      14'h03F8: c.onehot[3] = 1'b1;
      default:  c.hit = 1'b0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/nvs_strobe_det.sv
module nvs_strobe_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  output logic rd_evt,
  output logic wr_evt
);
  logic ce_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_n_q <= 1'b1;
    else        ce_n_q <= ce_n;
  end

  // Read strobe: first cycle with chip enable low while write is inactive.
  assign rd_evt = ce_n_q & ~ce_n & we_n;
  // Any cycle in which a write is active.
  assign wr_evt = ~ce_n & ~we_n;
endmodule

// File: rtl/nvs_key_match.sv
module nvs_key_match
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int STEP_W = 3
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [STEP_W-1:0]  step,
  output logic               step_hit,
  output logic               first_hit,
  output logic               cmd_hit,
  output logic [NUM_CMD-1:0] cmd_onehot
);
  localparam int NUM_KEYS = SEQ_LEN - 1;

  logic [KEY_W-1:0]    key_bits;
  logic [NUM_KEYS-1:0] key_eq;
  cmd_t                cmd;

  assign key_bits = addr[KEY_W-1:0];

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
    assign key_eq[g] = (key_bits == key_at(g));
  end

  always_comb begin
    step_hit = 1'b0;
    for (int i = 0; i < NUM_KEYS; i++)
      if (step == STEP_W'(i)) step_hit = key_eq[i];
  end

  assign first_hit  = key_eq[0];
  assign cmd        = cmd_lookup(key_bits);
  assign cmd_hit    = cmd.hit;
  assign cmd_onehot = cmd.onehot;
endmodule

// File: rtl/nvs_seq_fsm.sv
module nvs_seq_fsm
  import nvs_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic               rd_evt,
  input  logic               wr_evt,
  input  logic               step_hit,
  input  logic               first_hit,
  input  logic               cmd_hit,
  input  logic [NUM_CMD-1:0] cmd_onehot,
  output logic [STEP_W-1:0]  step,
  output logic [NUM_CMD-1:0] cmd_pulse
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_LEN - 1);
  localparam logic [STEP_W-1:0] ONE  = STEP_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step      <= '0;
      cmd_pulse <= '0;
    end else begin
      cmd_pulse <= '0;
      if (hold || wr_evt) begin
        step <= '0;
      end else if (rd_evt) begin
        if (step == LAST) begin
          if (cmd_hit) cmd_pulse <= cmd_onehot;
          step <= (!cmd_hit && first_hit) ? ONE : '0;
        end else if (step_hit) begin
          step <= step + ONE;
        end else begin
          step <= first_hit ? ONE : '0;
        end
      end
    end
  end
endmodule

// File: rtl/nvs_unlock_seq.sv
module nvs_unlock_seq
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               we_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               vcc_ok,
  input  logic               seq_busy,
  output logic [NUM_CMD-1:0] cmd_pulse
);
  localparam int STEP_W = $clog2(SEQ_LEN);

  logic               rd_evt;
  logic               wr_evt;
  logic               hold;
  logic               step_hit;
  logic               first_hit;
  logic               cmd_hit;
  logic [NUM_CMD-1:0] cmd_onehot;
  logic [STEP_W-1:0]  seq_step;

  assign hold = ~vcc_ok | seq_busy;

  nvs_strobe_det u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .we_n   (we_n),
    .rd_evt (rd_evt),
    .wr_evt (wr_evt)
  );

  nvs_key_match #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_match (
    .addr       (addr),
    .step       (seq_step),
    .step_hit   (step_hit),
    .first_hit  (first_hit),
    .cmd_hit    (cmd_hit),
    .cmd_onehot (cmd_onehot)
  );

  nvs_seq_fsm #(.STEP_W(STEP_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .rd_evt     (rd_evt),
    .wr_evt     (wr_evt),
    .step_hit   (step_hit),
    .first_hit  (first_hit),
    .cmd_hit    (cmd_hit),
    .cmd_onehot (cmd_onehot),
    .step       (seq_step),
    .cmd_pulse  (cmd_pulse)
  );
endmodule

// File: rtl/nvs_unlock_seq_chk.sv
module nvs_unlock_seq_chk #(
  parameter int ADDR_W  = 15,
  parameter int STEP_W  = 3,
  parameter int NUM_CMD = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vcc_ok,
  input logic               seq_busy,
  input logic               rd_evt,
  input logic               wr_evt,
  input logic [ADDR_W-1:0]  addr,
  input logic [STEP_W-1:0]  seq_step,
  input logic [NUM_CMD-1:0] cmd_pulse
);
  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_pulse)); // R11
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse != '0) |=> (cmd_pulse == '0)); // R11
  AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse != '0) |-> $past(rd_evt)); // R2
  AST_PULSE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse != '0) |-> (seq_step == '0)); // R2
  AST_ADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |-> !$isunknown(addr)); // R5
  AST_WRITE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (seq_step == '0) && (cmd_pulse == '0)); // R6
  AST_LOW_VCC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |=> (seq_step == '0) && (cmd_pulse == '0)); // R9
  AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> (seq_step == '0) && (cmd_pulse == '0)); // R10
endmodule

bind nvs_unlock_seq nvs_unlock_seq_chk #(
  .ADDR_W(ADDR_W), .STEP_W(STEP_W), .NUM_CMD(nvs_pkg::NUM_CMD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vcc_ok    (vcc_ok),
  .seq_busy  (seq_busy),
  .rd_evt    (rd_evt),
  .wr_evt    (wr_evt),
  .addr      (addr),
  .seq_step  (seq_step),
  .cmd_pulse (cmd_pulse)
);

// File: tb/nvs_unlock_seq_tb.sv
`timescale 1ns/1ps
module nvs_unlock_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1;
  logic        we_n = 1'b1;
  logic [14:0] addr = '0;
  logic        vcc_ok = 1'b1;
  logic        seq_busy = 1'b0;
  logic [3:0]  cmd_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [3:0] q_exp[$];
  string      q_tag[$];

  localparam logic [14:0] ST = 15'h0FC0, RC = 15'h0C63,
                          EN = 15'h07F0, DS = 15'h03F8;

  always #2.5 clk = ~clk;

  nvs_unlock_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .vcc_ok(vcc_ok), .seq_busy(seq_busy), .cmd_pulse(cmd_pulse)
  );

  function automatic logic [14:0] key(input int i);
    logic [14:0] k[5] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F};
    return k[i];
  endfunction

  // Monitor: compares each expected item with the output one step after the edge.
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      logic [3:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (cmd_pulse !== e) begin
        failures++;
        $display("FAIL %s cmd_pulse actual=%b expected=%b", t, cmd_pulse, e);
      end
    end else if (rst_n && cmd_pulse !== 4'b0) begin
      checks++;
      failures++;
      $display("FAIL R11 unexpected cmd_pulse actual=%b expected=0000", cmd_pulse);
    end
  end

  task automatic do_read(input logic [14:0] a, input logic [3:0] e, input string t);
    @(negedge clk);
    addr = a; we_n = 1'b1; ce_n = 1'b0;
    q_exp.push_back(e); q_tag.push_back(t);
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [14:0] a, input string t);
    @(negedge clk);
    addr = a; we_n = 1'b0; ce_n = 1'b0;
    q_exp.push_back(4'b0); q_tag.push_back(t);
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic keys(input int from, input int upto, input logic [14:0] hi, input string t);
    for (int i = from; i <= upto; i++) do_read(key(i) | hi, 4'b0, t);
  endtask

  task automatic full_seq(input logic [14:0] last, input logic [3:0] e, input logic [14:0] hi,
                          input string t);
    keys(0, 4, hi, t);
    do_read(last | hi, e, t);
  endtask

  task automatic idle_check(input string t);
    q_exp.push_back(4'b0); q_tag.push_back(t);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (cmd_pulse !== 4'b0) begin
      failures++;
      $display("FAIL R1 reset cmd_pulse actual=%b expected=0000", cmd_pulse);
    end
    // R1: first key accepted straight out of reset
    full_seq(ST, 4'b0001, 15'h0, "R1");
    full_seq(ST, 4'b0001, 15'h0, "R2");
    idle_check("R11");
    full_seq(RC, 4'b0010, 15'h0, "R3");
    full_seq(EN, 4'b0100, 15'h0, "R4");
    full_seq(DS, 4'b1000, 15'h0, "R4");
    // R5: bit 14 set on every address
    full_seq(ST, 4'b0001, 15'h4000, "R5");
    full_seq(RC, 4'b0010, 15'h4000, "R5");
    // R6: write after three keys aborts
    keys(0, 2, 15'h0, "R6");
    do_write(15'h0100, "R6");
    keys(3, 4, 15'h0, "R6");
    do_read(ST, 4'b0, "R6");
    full_seq(ST, 4'b0001, 15'h0, "R6");
    // R7: wrong address at step two aborts
    keys(0, 1, 15'h0, "R7");
    do_read(15'h1111, 4'b0, "R7");
    keys(2, 4, 15'h0, "R7");
    do_read(ST, 4'b0, "R7");
    // R7: first key in mid-sequence restarts
    keys(0, 1, 15'h0, "R7");
    full_seq(EN, 4'b0100, 15'h0, "R7");
    // R7: out-of-order keys
    do_read(key(0), 4'b0, "R7");
    do_read(key(2), 4'b0, "R7");
    keys(1, 4, 15'h0, "R7");
    do_read(DS, 4'b0, "R7");
    // R8: unrecognised sixth address
    full_seq(15'h1234, 4'b0, 15'h0, "R8");
    full_seq(15'h0E38, 4'b0, 15'h0, "R8");
    full_seq(RC, 4'b0010, 15'h0, "R8");
    // R9: supply dip mid-sequence
    keys(0, 2, 15'h0, "R9");
    @(negedge clk); vcc_ok = 1'b0;
    idle_check("R9");
    vcc_ok = 1'b1;
    keys(3, 4, 15'h0, "R9");
    do_read(ST, 4'b0, "R9");
    // R9: supply low for the whole sequence
    vcc_ok = 1'b0;
    full_seq(ST, 4'b0, 15'h0, "R9");
    vcc_ok = 1'b1;
    full_seq(ST, 4'b0001, 15'h0, "R9");
    // R10: busy during sixth read, then busy dip mid-sequence
    keys(0, 4, 15'h0, "R10");
    seq_busy = 1'b1;
    do_read(RC, 4'b0, "R10");
    seq_busy = 1'b0;
    keys(0, 3, 15'h0, "R10");
    @(negedge clk); seq_busy = 1'b1;
    idle_check("R10");
    seq_busy = 1'b0;
    do_read(key(4), 4'b0, "R10");
    do_read(RC, 4'b0, "R10");
    full_seq(RC, 4'b0010, 15'h0, "R10");
    idle_check("R11");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule